// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Unit

This block resolves read-after-write data hazards for a five-stage integer pipeline whose stages are fetch, decode, execute, memory and write-back. For each register operand of the instruction in execute, it compares the operand against the destinations held in the two later pipeline registers. It then drives a two-bit mux select that picks the register-file value, the ALU result held after execute, or the value held after memory. Three operands are handled: the two ALU sources and the store-data register. Each operand has its own select.

The same block watches for a load in execute whose destination is read by the instruction in decode. The loaded word exists only once the memory stage has finished, so bypassing alone cannot deliver it in time. In that case the block holds the program counter and the fetch/decode register for one cycle and turns the decode/execute entry into a bubble. One cycle later the load has reached write-back and the consumer is in execute, so the consumer takes the loaded value through the memory/write-back bypass.

Every hazard that is not a load-use hazard is resolved by bypass alone, with no lost cycle. The unit is purely combinational and sits between the pipeline registers, which are outside it. Its pins are plain control signals and carry no handshake.

Top module: `hazard_unit`

## Requirements
- R1: When an execute operand equals `exm_rd`, `exm_wr` is 1 and `exm_rd` is nonzero, that operand's select is 2'b10, which picks the ALU result after execute.
- R2: When the operand matches `mwb_rd` with `mwb_wr` 1 and `mwb_rd` nonzero, and R1 does not apply, the select is 2'b01, which picks the value after memory.
- R3: When both later stages match the same operand and both write, the select is 2'b10, because the newer value wins.
- R4: When no enabled destination matches the operand, the select is 2'b00, which picks the register file. This covers a matching destination whose write enable is 0.
- R5: Register number 0 is never bypassed, even if a later stage claims to write register 0. Its select is 2'b00.
- R6: Each operand is selected on its own. Slice 0 is ALU source A, slice 1 is ALU source B and slice 2 is store data. Different slices may carry different selects in the same cycle.
- R7: When `ex_is_load` is 1, `ex_dst` is nonzero and `ex_dst` equals any entry of `id_src`, the outputs `pc_hold`, `ifid_hold` and `idex_bubble` are all 1.
- R8: No stall is raised in three cases: the instruction in execute is not a load, the load's destination is register 0, or no decode operand matches. In these cases all three stall outputs are 0.
- R9: No select ever takes the value 2'b11.
- R10: In a load-use sequence the stall lasts exactly one cycle. In the next cycle the load sits in the memory stage and the bubble is in execute, and no stall is raised. One cycle after that the consumer gets select 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src | input | NSRC x AW | Source register numbers of the instruction in execute (A, B, store data) |
| exm_rd | input | AW | Destination register held after execute |
| exm_wr | input | 1 | Register-write flag held after execute |
| mwb_rd | input | AW | Destination register held after memory |
| mwb_wr | input | 1 | Register-write flag held after memory |
| id_src | input | NSRC x AW | Source register numbers of the instruction in decode |
| ex_is_load | input | 1 | Instruction in execute is a load |
| ex_dst | input | AW | Destination register of the instruction in execute |
| ex_fwd_sel | output | NSRC x 2 | Operand mux selects, one per execute operand |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble | output | 1 | Clear control bits entering execute |

## Verification
A wrong priority or a wrong compare shows up at once on `ex_fwd_sel`, in the same cycle the operand pattern is applied. The ALU would then receive a stale value or the wrong stage's value. A stuck or missing compare in the load-use path shows up as a stall flag that disagrees with the decode sources. The worst cases are a stall that repeats while the load has moved on, or a consumer that reaches execute without the 2'b01 select. The three-cycle load-use sequence exposes both faults within three applied vectors.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef enum logic [1:0] {
    SEL_REGFILE = 2'b00,
    SEL_MEMWB   = 2'b01,
    SEL_EXMEM   = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/bypass_select.sv
module bypass_select
  import hazard_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] exm_rd,
  input  logic          exm_wr,
  input  logic [AW-1:0] mwb_rd,
  input  logic          mwb_wr,
  output fwd_sel_e      sel
);
  logic src_live;
  logic hit_exm;
  logic hit_mwb;

  assign src_live = (src != '0);
  assign hit_exm  = src_live && exm_wr && (exm_rd == src);
  assign hit_mwb  = src_live && mwb_wr && (mwb_rd == src);

  // newer producer first
  always_comb begin
    if (hit_exm)      sel = SEL_EXMEM;
    else if (hit_mwb) sel = SEL_MEMWB;
    else              sel = SEL_REGFILE;
  end
endmodule

// File: rtl/loaduse_detect.sv
module loaduse_detect #(
  parameter int AW   = 5,
  parameter int NSRC = 3
) (
  input  logic [NSRC-1:0][AW-1:0] id_src,
  input  logic                    ex_is_load,
  input  logic [AW-1:0]           ex_dst,
  output logic                    stall
);
  logic [NSRC-1:0] hit;

  for (genvar g = 0; g < NSRC; g++) begin : g_cmp
    assign hit[g] = (id_src[g] == ex_dst);
  end

  assign stall = ex_is_load && (ex_dst != '0) && (|hit);
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hazard_pkg::*;
#(
  parameter int AW   = 5,
  parameter int NSRC = 3
) (
  input  logic [NSRC-1:0][AW-1:0] ex_src,
  input  logic [AW-1:0]           exm_rd,
  input  logic                    exm_wr,
  input  logic [AW-1:0]           mwb_rd,
  input  logic                    mwb_wr,
  input  logic [NSRC-1:0][AW-1:0] id_src,
  input  logic                    ex_is_load,
  input  logic [AW-1:0]           ex_dst,
  output logic [NSRC-1:0][1:0]    ex_fwd_sel,
  output logic                    pc_hold,
  output logic                    ifid_hold,
  output logic                    idex_bubble
);
  logic stall;

  for (genvar g = 0; g < NSRC; g++) begin : g_opnd
    fwd_sel_e sel_g;
    bypass_select #(.AW(AW)) u_sel (
      .src    (ex_src[g]),
      .exm_rd (exm_rd),
      .exm_wr (exm_wr),
      .mwb_rd (mwb_rd),
      .mwb_wr (mwb_wr),
      .sel    (sel_g)
    );
    assign ex_fwd_sel[g] = sel_g;
  end

  loaduse_detect #(.AW(AW), .NSRC(NSRC)) u_lu (
    .id_src     (id_src),
    .ex_is_load (ex_is_load),
    .ex_dst     (ex_dst),
    .stall      (stall)
  );

  assign pc_hold     = stall;
  assign ifid_hold   = stall;
  assign idex_bubble = stall;
endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk #(
  parameter int AW   = 5,
  parameter int NSRC = 3
) (
  input logic [NSRC-1:0][AW-1:0] ex_src,
  input logic [AW-1:0]           exm_rd,
  input logic                    exm_wr,
  input logic [AW-1:0]           mwb_rd,
  input logic                    mwb_wr,
  input logic [NSRC-1:0][AW-1:0] id_src,
  input logic                    ex_is_load,
  input logic [AW-1:0]           ex_dst,
  input logic [NSRC-1:0][1:0]    ex_fwd_sel,
  input logic                    pc_hold,
  input logic                    ifid_hold,
  input logic                    idex_bubble
);
  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      p_sel_legal_r9: assert (ex_fwd_sel[i] != 2'b11);
      p_zero_src_r5: assert ((ex_src[i] != '0) || (ex_fwd_sel[i] == 2'b00));
      p_exmem_wins_r3: assert (!(exm_wr && (exm_rd != '0) && (exm_rd == ex_src[i]))
                               || (ex_fwd_sel[i] == 2'b10));
      p_wb_source_r2: assert ((ex_fwd_sel[i] != 2'b01)
                              || (mwb_wr && (mwb_rd == ex_src[i])));
    end
    p_stall_cause_r8: assert (!idex_bubble || (ex_is_load && (ex_dst != '0)));
    p_stall_hold_r7: assert (idex_bubble == (pc_hold && ifid_hold));
  end
endmodule

bind hazard_unit hazard_unit_chk #(.AW(AW), .NSRC(NSRC)) u_chk (.*);

// File: tb/hazard_unit_test.sv
module hazard_unit_test;
  localparam int AW   = 5;
  localparam int NSRC = 3;

  typedef struct {
    logic [NSRC-1:0][1:0] sel;
    logic                 stall;
    string                tag;
  } exp_t;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [NSRC-1:0][AW-1:0] ex_src = '0;
  logic [AW-1:0]           exm_rd = '0;
  logic                    exm_wr = 1'b0;
  logic [AW-1:0]           mwb_rd = '0;
  logic                    mwb_wr = 1'b0;
  logic [NSRC-1:0][AW-1:0] id_src = '0;
  logic                    ex_is_load = 1'b0;
  logic [AW-1:0]           ex_dst = '0;
  logic [NSRC-1:0][1:0]    ex_fwd_sel;
  logic                    pc_hold, ifid_hold, idex_bubble;

  hazard_unit #(.AW(AW), .NSRC(NSRC)) uut (.*);

  exp_t q[$];
  int   applied = 0;
  int   bad = 0;
  bit   done = 1'b0;

  function automatic logic [1:0] ref_sel(logic [AW-1:0] s);
    if (s == '0) return 2'b00;
    if (exm_wr && exm_rd == s) return 2'b10;
    if (mwb_wr && mwb_rd == s) return 2'b01;
    return 2'b00;
  endfunction

  task automatic apply(input logic [AW-1:0] a, b, sd,
                       input logic [AW-1:0] erd, input logic ewr,
                       input logic [AW-1:0] wrd, input logic wwr,
                       input logic [AW-1:0] ia, ib, isd,
                       input logic ld, input logic [AW-1:0] dst,
                       input string tag);
    exp_t e;
    @(posedge clk);
    ex_src = {sd, b, a}; exm_rd = erd; exm_wr = ewr;
    mwb_rd = wrd; mwb_wr = wwr; id_src = {isd, ib, ia};
    ex_is_load = ld; ex_dst = dst;
    for (int i = 0; i < NSRC; i++) e.sel[i] = ref_sel(ex_src[i]);
    e.stall = ld && (dst != '0) && ((ia == dst) || (ib == dst) || (isd == dst));
    e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        applied++;
        if (ex_fwd_sel !== e.sel) begin
          bad++;
          $display("FAIL %s sel got %b exp %b", e.tag, ex_fwd_sel, e.sel);
        end
        if ({pc_hold, ifid_hold, idex_bubble} !== {3{e.stall}}) begin
          bad++;
          $display("FAIL %s stall got %b%b%b exp %b", e.tag,
                   pc_hold, ifid_hold, idex_bubble, e.stall);
        end
      end
    end
  end

  initial begin : driver
    apply(0,0,0, 0,0, 0,0, 0,0,0, 0,0, "idle R4");
    apply(3,4,0, 3,1, 0,0, 0,0,0, 0,0, "R1 exmem");
    apply(3,4,0, 0,0, 4,1, 0,0,0, 0,0, "R2 memwb");
    apply(6,6,6, 6,1, 6,1, 0,0,0, 0,0, "R3 priority");
    apply(7,9,0, 7,0, 9,0, 0,0,0, 0,0, "R4 write off");
    apply(0,0,0, 0,1, 0,1, 0,0,0, 0,0, "R5 zero reg");
    apply(2,5,8, 2,1, 8,1, 0,0,0, 0,0, "R6 mixed");
    apply(1,1,2, 2,1, 1,1, 0,0,0, 0,0, "R6 store data");
    apply(0,0,0, 0,0, 0,0, 10,11,0, 1,11, "R7 load B");
    apply(0,0,0, 0,0, 0,0, 0,0,12, 1,12, "R7 load store-data");
    apply(0,0,0, 0,0, 0,0, 13,0,0, 0,13, "R8 not load");
    apply(0,0,0, 0,0, 0,0, 0,0,0, 1,0, "R8 load r0");
    apply(0,0,0, 0,0, 0,0, 14,15,16, 1,17, "R8 no match");
    // load-use sequence on register 8
    apply(1,2,0, 0,0, 0,0, 8,9,0, 1,8, "R10 stall cycle");
    apply(0,0,0, 8,1, 0,0, 8,9,0, 0,0, "R10 bubble cycle");
    apply(8,9,0, 0,0, 8,1, 0,0,0, 0,0, "R10 consumer memwb");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end
endmodule